// File: doc/BRIEF.md
# SMBus Host Controller Register Engine

A byte-wide register window for a system-management bus host. Software loads a target address byte, a command code, two data bytes and a 32-entry block buffer, then writes the control register with its start bit set. The engine decodes the protocol field, issues one abstract transaction on a request/response port to a target model in the same cycle, and then shows busy in the status register for a programmable number of clock cycles before it posts the completion status.

The window is 16 bytes, placed at a 16-aligned base taken from a 16-bit base input. It answers only when its enable input is high and the aligned base is nonzero. Status bits are cleared by writing ones. A kill bit in the control register aborts a pending command. The block data port walks an internal index that wraps after the last entry and returns to zero whenever the control register is read.

Top module: `smbus_host_regs`

## Requirements
- R1: Accesses decode only when `io_en_i` is 1, the aligned base (`io_base_i` with bits 3:0 forced to 0) is nonzero, and `io_addr_i[15:4]` equals `io_base_i[15:4]`. Any other access reads 0x00 and changes no register.
- R2: Offset 3 (command), 4 (address), 5 (data 0) and 6 (data 1) read back the last value written. Offset 2 (control) reads back the written value with bit 6 cleared. Offsets 1 and 8..15 read 0x00 and ignore writes. After reset every register reads 0x00.
- R3: A control write with bit 6 set, a present target and a valid protocol issues exactly one `tgt_req_o` pulse. Its kind is control bits 4:2, its address is address-register bits 7:1, its direction is address bit 0 (1 = read), and it carries the command, {data 1, data 0} and data 0 as the block length.
- R4: From the start write, status (offset 0) reads 0x01 for DELAY_CYC clock edges (the start edge included). It then reads the completion value: 0x02 on success.
- R5: If `tgt_present_i` is 0 at the start, no request is issued and the completion value is 0x04.
- R6: Protocol codes 0 (quick), 1 (byte), 2 (byte-data), 3 (word-data) and 5 (block) are valid. Codes 4, 6 and 7 issue no request and complete with 0x04.
- R7: Writing status with a 1 in bit 1, 2, 3 or 4 clears that bit. Zero bits leave the status unchanged.
- R8: A control write with bit 1 set while a command is pending sets status to 0x10, and that command's completion is never posted. With nothing pending, the kill bit has no effect on status.
- R9: Each read or write of offset 7 accesses the buffer entry at the current index, then advances the index, wrapping from 31 to 0. A read of offset 2 resets the index to 0.
- R10: Read transactions load their results at the start. Byte and byte-data load data 0 with `tgt_rdata_i[7:0]`. Word loads data 0 with the low byte and data 1 with the high byte. Block loads data 0 with `tgt_len_i` and the whole buffer with `tgt_blk_i` (entry i at bits 8i+7:8i).
- R11: A new start while busy restarts the delay and replaces the pending completion value with the new command's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_base_i | input | 16 | Window base; bits 3:0 ignored |
| io_en_i | input | 1 | Window enable |
| io_addr_i | input | 16 | Access address |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe (side effects at the clock edge) |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data (combinational) |
| tgt_req_o | output | 1 | One-cycle transaction request |
| tgt_kind_o | output | 3 | Protocol code |
| tgt_addr_o | output | 7 | Target address |
| tgt_rnw_o | output | 1 | 1 = read transaction |
| tgt_cmd_o | output | 8 | Command code |
| tgt_wdata_o | output | 16 | {data 1, data 0} |
| tgt_len_o | output | 8 | Block write length (data 0) |
| tgt_blk_o | output | 256 | Block buffer, entry i at bits 8i+7:8i |
| tgt_present_i | input | 1 | Target answers at `tgt_addr_o` |
| tgt_rdata_i | input | 16 | Read result, low byte in 7:0 |
| tgt_len_i | input | 8 | Block read length |
| tgt_blk_i | input | 256 | Block read data |

## Verification
The hardest state to reach is a command interrupted while it is pending: a kill or a second start has to land inside the busy window, and the status must then be checked both at once and after the original delay has run out. The bench times these writes by counting clock edges from the first start. It reads status on the last busy cycle and on the cycle after it, so the exact delay length is pinned. Buffer wrap is reached by writing three entries past the end before reading back, and random commands over present and absent addresses mix with every protocol code.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;
  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_CTL  = 4'h2;
  localparam logic [3:0] OFS_CMD  = 4'h3;
  localparam logic [3:0] OFS_ADDR = 4'h4;
  localparam logic [3:0] OFS_D0   = 4'h5;
  localparam logic [3:0] OFS_D1   = 4'h6;
  localparam logic [3:0] OFS_BLK  = 4'h7;

  localparam logic [7:0] ST_BUSY   = 8'h01;
  localparam logic [7:0] ST_DONE   = 8'h02;
  localparam logic [7:0] ST_DEVERR = 8'h04;
  localparam logic [7:0] ST_FAIL   = 8'h10;
  localparam logic [7:0] ST_W1C    = 8'h1e;

  localparam int CTL_START = 6;
  localparam int CTL_KILL  = 1;

  typedef enum logic [2:0] {
    PR_QUICK = 3'd0,
    PR_BYTE  = 3'd1,
    PR_BDATA = 3'd2,
    PR_WORD  = 3'd3,
    PR_BLOCK = 3'd5
  } proto_e;

  function automatic logic proto_ok(input logic [2:0] p);
    return (p <= 3'd3) || (p == 3'd5);
  endfunction
endpackage

// File: rtl/smbus_win_decode.sv
module smbus_win_decode #(
  parameter int AW     = 16,
  parameter int WIN_AW = 4
) (
  input  logic [AW-1:0]     base_i,
  input  logic              en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              hit_o,
  output logic [WIN_AW-1:0] ofs_o,
  output logic              rd_o,
  output logic              wr_o
);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << WIN_AW) - 1);

  logic active;
  assign active = en_i && ((base_i & ~LOW_MASK) != '0);
  assign hit_o  = active && (addr_i[AW-1:WIN_AW] == base_i[AW-1:WIN_AW]);
  assign ofs_o  = addr_i[WIN_AW-1:0];
  assign rd_o   = hit_o && rd_i;
  assign wr_o   = hit_o && wr_i;
endmodule

// File: rtl/smbus_blk_buf.sv
module smbus_blk_buf #(
  parameter int DEPTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic               idx_clr_i,
  input  logic [7:0]         wdata_i,
  input  logic               load_i,
  input  logic [DEPTH*8-1:0] load_data_i,
  output logic [7:0]         rdata_o,
  output logic [DEPTH*8-1:0] flat_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [7:0]    mem_q [DEPTH];
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nxt;

  assign idx_nxt = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  assign rdata_o = mem_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (idx_clr_i) idx_q <= '0;
    else if (wr_i || rd_i) idx_q <= idx_nxt;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (load_i) mem_q[g] <= load_data_i[g*8 +: 8];
      else if (wr_i && idx_q == IW'(g)) mem_q[g] <= wdata_i;
    end
    assign flat_o[g*8 +: 8] = mem_q[g];
  end

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && !idx_clr_i) |=>
      (idx_q == (($past(idx_q) == LAST) ? '0 : $past(idx_q) + 1'b1))); // R9
  AST_IDX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_clr_i |=> (idx_q == '0)); // R9
endmodule

// File: rtl/smbus_cmd_ctrl.sv
module smbus_cmd_ctrl
  import smbus_host_pkg::*;
#(
  parameter int DELAY_CYC = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  ofs_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  stat_o,
  output logic [7:0]  ctl_o,
  output logic [7:0]  cmd_o,
  output logic [7:0]  addr_o,
  output logic [7:0]  data0_o,
  output logic [7:0]  data1_o,
  output logic        blk_load_o,
  output logic        tgt_req_o,
  output logic [2:0]  tgt_kind_o,
  output logic [6:0]  tgt_addr_o,
  output logic        tgt_rnw_o,
  output logic [7:0]  tgt_cmd_o,
  output logic [15:0] tgt_wdata_o,
  output logic [7:0]  tgt_len_o,
  input  logic        tgt_present_i,
  input  logic [15:0] tgt_rdata_i,
  input  logic [7:0]  tgt_len_i
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(DELAY_CYC);

  logic [7:0]    stat_q, ctl_q, cmd_q, addr_q, d0_q, d1_q, next_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q;

  logic       ctl_wr, start, kill, issue, rnw;
  logic [2:0] kind;
  logic [7:0] fin;

  assign ctl_wr = wr_i && (ofs_i == OFS_CTL);
  assign start  = ctl_wr && wdata_i[CTL_START];
  assign kill   = ctl_wr && wdata_i[CTL_KILL] && pend_q;
  assign kind   = wdata_i[4:2];
  assign rnw    = addr_q[0];
  assign issue  = start && tgt_present_i && proto_ok(kind);
  assign fin    = issue ? ST_DONE : ST_DEVERR;

  assign tgt_req_o   = issue;
  assign tgt_kind_o  = kind;
  assign tgt_addr_o  = addr_q[7:1];
  assign tgt_rnw_o   = rnw;
  assign tgt_cmd_o   = cmd_q;
  assign tgt_wdata_o = {d1_q, d0_q};
  assign tgt_len_o   = d0_q;
  assign blk_load_o  = issue && rnw && (kind == PR_BLOCK);

  assign stat_o  = stat_q;
  assign ctl_o   = ctl_q;
  assign cmd_o   = cmd_q;
  assign addr_o  = addr_q;
  assign data0_o = d0_q;
  assign data1_o = d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0; ctl_q <= '0; cmd_q <= '0; addr_q <= '0;
      d0_q   <= '0; d1_q  <= '0; next_q <= '0;
      pend_q <= 1'b0; cnt_q <= '0;
    end else begin
      if (wr_i) begin
        unique case (ofs_i)
          OFS_STAT: stat_q <= stat_q & ~(wdata_i & ST_W1C);
          OFS_CTL:  ctl_q  <= wdata_i & ~(8'(1) << CTL_START);
          OFS_CMD:  cmd_q  <= wdata_i;
          OFS_ADDR: addr_q <= wdata_i;
          OFS_D0:   d0_q   <= wdata_i;
          OFS_D1:   d1_q   <= wdata_i;
          default: ;
        endcase
      end
      if (issue && rnw) begin
        unique case (kind)
          PR_BYTE, PR_BDATA: d0_q <= tgt_rdata_i[7:0];
          PR_WORD: begin d0_q <= tgt_rdata_i[7:0]; d1_q <= tgt_rdata_i[15:8]; end
          PR_BLOCK: d0_q <= tgt_len_i;
          default: ;
        endcase
      end
      if (start) begin
        stat_q <= ST_BUSY;
        pend_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
        next_q <= fin;
      end else if (kill) begin
        stat_q <= ST_FAIL;
        pend_q <= 1'b0;
      end else if (pend_q) begin
        if (cnt_q <= 1) begin
          stat_q <= next_q;
          pend_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  AST_BUSY_WHILE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (stat_q == ST_BUSY)); // R4
  AST_REQ_NEEDS_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |-> tgt_present_i); // R5
  AST_REQ_VALID_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |-> (tgt_kind_o inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5})); // R6
  AST_REQ_GOES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |=> (pend_q && stat_q == ST_BUSY)); // R3
  AST_KILL_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill && !start) |=> (stat_q == ST_FAIL && !pend_q)); // R8
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> !ctl_q[CTL_START]); // R2
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbus_host_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BLK_DEPTH = 32,
  parameter int DELAY_CYC = 8,
  localparam int BW       = BLK_DEPTH * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] io_base_i,
  input  logic          io_en_i,
  input  logic [AW-1:0] io_addr_i,
  input  logic          io_wr_i,
  input  logic          io_rd_i,
  input  logic [7:0]    io_wdata_i,
  output logic [7:0]    io_rdata_o,
  output logic          tgt_req_o,
  output logic [2:0]    tgt_kind_o,
  output logic [6:0]    tgt_addr_o,
  output logic          tgt_rnw_o,
  output logic [7:0]    tgt_cmd_o,
  output logic [15:0]   tgt_wdata_o,
  output logic [7:0]    tgt_len_o,
  output logic [BW-1:0] tgt_blk_o,
  input  logic          tgt_present_i,
  input  logic [15:0]   tgt_rdata_i,
  input  logic [7:0]    tgt_len_i,
  input  logic [BW-1:0] tgt_blk_i
);
  logic       hit, rd, wr, blk_load;
  logic [3:0] ofs;
  logic [7:0] stat, ctl, cmd, addr, d0, d1, blk_rd;

  smbus_win_decode #(.AW(AW), .WIN_AW(4)) u_dec (
    .base_i(io_base_i), .en_i(io_en_i), .addr_i(io_addr_i),
    .rd_i(io_rd_i), .wr_i(io_wr_i),
    .hit_o(hit), .ofs_o(ofs), .rd_o(rd), .wr_o(wr)
  );

  smbus_cmd_ctrl #(.DELAY_CYC(DELAY_CYC)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr), .ofs_i(ofs), .wdata_i(io_wdata_i),
    .stat_o(stat), .ctl_o(ctl), .cmd_o(cmd), .addr_o(addr),
    .data0_o(d0), .data1_o(d1), .blk_load_o(blk_load),
    .tgt_req_o, .tgt_kind_o, .tgt_addr_o, .tgt_rnw_o, .tgt_cmd_o,
    .tgt_wdata_o, .tgt_len_o, .tgt_present_i, .tgt_rdata_i, .tgt_len_i
  );

  smbus_blk_buf #(.DEPTH(BLK_DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .wr_i(wr && ofs == OFS_BLK), .rd_i(rd && ofs == OFS_BLK),
    .idx_clr_i(rd && ofs == OFS_CTL), .wdata_i(io_wdata_i),
    .load_i(blk_load), .load_data_i(tgt_blk_i),
    .rdata_o(blk_rd), .flat_o(tgt_blk_o)
  );

  always_comb begin
    io_rdata_o = '0;
    if (hit) begin
      unique case (ofs)
        OFS_STAT: io_rdata_o = stat;
        OFS_CTL:  io_rdata_o = ctl;
        OFS_CMD:  io_rdata_o = cmd;
        OFS_ADDR: io_rdata_o = addr;
        OFS_D0:   io_rdata_o = d0;
        OFS_D1:   io_rdata_o = d1;
        OFS_BLK:  io_rdata_o = blk_rd;
        default:  io_rdata_o = '0;
      endcase
    end
  end

  AST_MISS_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && !hit) |=> ($stable(cmd) && $stable(addr) && $stable(d1))); // R1
endmodule

// File: tb/smbus_host_regs_test.sv
module smbus_host_regs_test;
  localparam int DLY = 8;
  localparam int DEP = 32;
  localparam logic [15:0] BASE = 16'h0c40;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [15:0] base = BASE, a = 0;
  logic en = 1, wr = 0, rd = 0;
  logic [7:0] wd = 0, rdat;
  logic req, rnw, present;
  logic [2:0] kind;
  logic [6:0] taddr;
  logic [7:0] tcmd, tlen, len_in;
  logic [15:0] twd, rdat_in;
  logic [DEP*8-1:0] blk_o, blk_in;

  smbus_host_regs #(.DELAY_CYC(DLY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .io_base_i(base), .io_en_i(en),
    .io_addr_i(a), .io_wr_i(wr), .io_rd_i(rd), .io_wdata_i(wd), .io_rdata_o(rdat),
    .tgt_req_o(req), .tgt_kind_o(kind), .tgt_addr_o(taddr), .tgt_rnw_o(rnw),
    .tgt_cmd_o(tcmd), .tgt_wdata_o(twd), .tgt_len_o(tlen), .tgt_blk_o(blk_o),
    .tgt_present_i(present), .tgt_rdata_i(rdat_in), .tgt_len_i(len_in), .tgt_blk_i(blk_in)
  );

  function automatic logic f_present(input logic [6:0] ad); return ad[6:3] == 4'b1010; endfunction
  function automatic logic [15:0] f_word(input logic [7:0] c); return {c ^ 8'ha5, c}; endfunction
  function automatic logic [7:0] f_blk(input logic [7:0] c, input int i); return c + 8'(i * 3); endfunction
  function automatic logic f_ok(input logic [2:0] k); return k <= 3 || k == 5; endfunction

  // target model
  always_comb begin
    present = f_present(taddr);
    rdat_in = f_word(tcmd);
    len_in  = {3'b0, tcmd[4:0]};
    for (int i = 0; i < DEP; i++) blk_in[i*8 +: 8] = f_blk(tcmd, i);
  end

  int n_req = 0;
  logic [2:0] c_kind; logic [6:0] c_addr; logic c_rnw;
  logic [7:0] c_cmd, c_len, c_blk3; logic [15:0] c_wd;
  always @(posedge clk) if (req) begin
    n_req++; c_kind = kind; c_addr = taddr; c_rnw = rnw; c_cmd = tcmd;
    c_wd = twd; c_len = tlen; c_blk3 = blk_o[31:24];
  end

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // tasks start and end at a negedge
  task automatic wr_raw(input logic [15:0] ad, input logic [7:0] d);
    a = ad; wd = d; wr = 1; @(posedge clk); @(negedge clk); wr = 0;
  endtask
  task automatic rd_raw(input logic [15:0] ad, output logic [7:0] d);
    a = ad; rd = 1; #1 d = rdat; @(posedge clk); @(negedge clk); rd = 0;
  endtask
  task automatic wreg(input logic [3:0] o, input logic [7:0] d); wr_raw(BASE | 16'(o), d); endtask
  task automatic rreg(input logic [3:0] o, output logic [7:0] d); rd_raw(BASE | 16'(o), d); endtask
  task automatic expect_reg(input string tag, input logic [3:0] o, input logic [7:0] e);
    logic [7:0] v; rreg(o, v); chk(tag, v, e);
  endtask
  // call right after a start write: checks busy window and final status
  task automatic busy_then(input string tag, input logic [7:0] fin);
    expect_reg({tag, " busy first"}, 0, 8'h01);
    repeat (DLY - 2) @(negedge clk);
    expect_reg({tag, " busy last"}, 0, 8'h01);
    expect_reg({tag, " final"}, 0, fin);
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int r0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset values
    expect_reg("R2 reset stat", 0, 0);
    expect_reg("R2 reset ctl", 2, 0);
    expect_reg("R2 reset d0", 5, 0);

    // R2 random readback
    for (int i = 0; i < 20; i++) begin
      logic [7:0] x, y, z, w;
      x = 8'($urandom); y = 8'($urandom); z = 8'($urandom); w = 8'($urandom);
      wreg(3, x); wreg(4, y); wreg(5, z); wreg(6, w);
      expect_reg("R2 cmd", 3, x); expect_reg("R2 addr", 4, y);
      expect_reg("R2 d0", 5, z); expect_reg("R2 d1", 6, w);
    end
    wreg(2, 8'hbf);
    expect_reg("R2 ctl no start", 2, 8'hbf);
    wreg(3, 8'h5a);
    wreg(9, 8'hff); wreg(1, 8'hff);
    expect_reg("R2 ofs9 zero", 9, 0);
    expect_reg("R2 ofs1 zero", 1, 0);
    expect_reg("R2 ofs15 zero", 15, 0);
    expect_reg("R2 cmd untouched", 3, 8'h5a);
    expect_reg("R2 stat untouched", 0, 0);

    // R1 window decode
    wreg(5, 8'h33);
    en = 0; rreg(5, v); chk("R1 disabled read", v, 0);
    wreg(5, 8'h99); en = 1;
    expect_reg("R1 disabled write", 5, 8'h33);
    wr_raw(BASE + 16'h15, 8'h77);
    expect_reg("R1 outside write", 5, 8'h33);
    rd_raw(BASE + 16'h15, v); chk("R1 outside read", v, 0);
    base = 16'h000c; rd_raw(16'h0005, v); chk("R1 zero base read", v, 0);
    base = BASE | 16'h000f; expect_reg("R1 low base bits ignored", 5, 8'h33);
    base = BASE;

    // R3/R4 byte-data write
    r0 = n_req;
    wreg(4, 8'ha4); wreg(3, 8'h3c); wreg(5, 8'h11); wreg(6, 8'h22);
    wreg(2, 8'h48);
    chk("R3 one request", n_req - r0, 1);
    chk("R3 kind", c_kind, 2); chk("R3 addr", c_addr, 7'h52);
    chk("R3 rnw", c_rnw, 0); chk("R3 cmd", c_cmd, 8'h3c);
    chk("R3 wdata", c_wd, 16'h2211);
    busy_then("R4", 8'h02);
    expect_reg("R2 start reads zero", 2, 8'h08);

    // R7 W1C
    wreg(0, 8'h00); expect_reg("R7 zero keeps", 0, 8'h02);
    wreg(0, 8'hfd); expect_reg("R7 other bits keep", 0, 8'h02);
    wreg(0, 8'h02); expect_reg("R7 clear", 0, 8'h00);

    // R10 word read
    wreg(4, 8'ha5); wreg(3, 8'h77); wreg(2, 8'h4c);
    chk("R10 word rnw", c_rnw, 1);
    expect_reg("R10 word d0", 5, f_word(8'h77) >> 0 & 8'hff);
    expect_reg("R10 word d1", 6, f_word(8'h77) >> 8);
    repeat (DLY) @(negedge clk);
    expect_reg("R10 word status", 0, 8'h02);

    // R10 byte read
    wreg(3, 8'h41); wreg(2, 8'h44);
    expect_reg("R10 byte d0", 5, 8'h41);
    repeat (DLY) @(negedge clk);

    // R5 absent target
    r0 = n_req;
    wreg(4, 8'h20); wreg(2, 8'h48);
    chk("R5 no request", n_req - r0, 0);
    busy_then("R5", 8'h04);

    // R6 invalid protocols
    wreg(4, 8'ha0);
    for (int k = 4; k < 8; k++) if (k != 5) begin
      r0 = n_req;
      wreg(2, 8'h40 | 8'(k << 2));
      chk("R6 no request", n_req - r0, 0);
      busy_then("R6", 8'h04);
    end

    // R8 kill
    wreg(2, 8'h40);
    repeat (2) @(negedge clk);
    wreg(2, 8'h02);
    expect_reg("R8 failed", 0, 8'h10);
    repeat (DLY + 2) @(negedge clk);
    expect_reg("R8 discarded", 0, 8'h10);
    wreg(0, 8'h10); expect_reg("R7 clear failed", 0, 0);
    wreg(2, 8'h02); expect_reg("R8 idle kill no effect", 0, 0);

    // R11 restart while busy
    wreg(4, 8'h20); wreg(2, 8'h40);
    repeat (3) @(negedge clk);
    wreg(4, 8'ha0); wreg(2, 8'h40);
    busy_then("R11", 8'h02);

    // R9 buffer wrap and index clear
    rreg(2, v);
    for (int i = 0; i < DEP + 3; i++) wreg(7, 8'(i));
    rreg(2, v);
    for (int i = 0; i < DEP; i++) expect_reg("R9 entry", 7, (i < 3) ? 8'(DEP + i) : 8'(i));
    expect_reg("R9 wrap read", 7, 8'(DEP));
    rreg(7, v); rreg(2, v);
    expect_reg("R9 clear on ctl read", 7, 8'(DEP));

    // R10/R3 block write and block read
    wreg(4, 8'ha0); wreg(5, 8'h05); wreg(2, 8'h54);
    chk("R3 block len", c_len, 5); chk("R3 block data", c_blk3, 8'h03);
    repeat (DLY) @(negedge clk);
    wreg(4, 8'ha1); wreg(3, 8'h0d); wreg(2, 8'h54);
    expect_reg("R10 block count", 5, 8'h0d);
    rreg(2, v);
    for (int i = 0; i < 4; i++) expect_reg("R10 block data", 7, f_blk(8'h0d, i));
    repeat (DLY) @(negedge clk);

    // random commands
    for (int i = 0; i < 30; i++) begin
      logic [7:0] ad; logic [2:0] k; logic ok;
      ad = ($urandom & 1) ? {4'b1010, 4'($urandom)} : 8'($urandom);
      k = 3'($urandom);
      ok = f_present(ad[7:1]) && f_ok(k);
      r0 = n_req;
      wreg(4, ad); wreg(2, 8'h40 | {3'b0, k, 2'b0});
      chk(ok ? "R3 random req" : "R6 random no req", n_req - r0, ok ? 1 : 0);
      repeat (DLY) @(negedge clk);
      expect_reg(ok ? "R4 random status" : "R5 random status", 0, ok ? 8'h02 : 8'h04);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule